// File: doc/BRIEF.md
# Instruction Decoder with Datapath Control

This block turns one 32-bit instruction word of a small load-free RISC subset into the fields and control bits that a register-file datapath needs. These are the two source register indices, a destination index, a 32-bit extended immediate, an ALU operation code, an ALU operand-B source select, a register write enable, a jump flag and a link flag. The link flag tells the write-back path to store the address of the following instruction (PC+4) instead of the ALU result.

Decoding goes by format. Opcode 0 selects the register-register group, and the low six bits then pick the operation. A small set of other opcodes selects register-immediate operations, and two opcodes select the plain and linking jumps. Every other opcode or function code is let through without effect: it writes no register and takes no jump. The decoded bundle is captured in an output register with a clock enable, so the block can sit as a pipeline stage boundary.

Top module: `instr_decode_unit`

## Requirements
- R1: `src_a_o` is instruction bits [25:21] and `src_b_o` is bits [20:16] for every instruction word.
- R2: With opcode (bits [31:26]) 000000, function codes (bits [5:0]) 100001, 100011, 100100, 100101, 100110 and 100111 give `alu_op_o` values 0 (add), 1 (subtract), 2 (and), 3 (or), 4 (xor) and 5 (nor). They also give `alu_src_imm_o`=0 and `dst_o` = bits [15:11].
- R3: Opcodes 001001, 001100, 001101 and 001110 give `alu_op_o` 0, 2, 3 and 4, with `alu_src_imm_o`=1 and `dst_o` = bits [20:16].
- R4: `imm_o` is bits [15:0] sign-extended to 32 bits when the opcode is 001001, and zero-extended for every other opcode.
- R5: Opcode 000010 gives `jump_o`=1, `link_o`=0, `reg_we_o`=0 and `dst_o`=0.
- R6: Opcode 000011 gives `jump_o`=1, `link_o`=1, `dst_o`=31 and `reg_we_o`=1.
- R7: Any other opcode, or opcode 000000 with any other function code, gives `reg_we_o`=0, `jump_o`=0, `link_o`=0, `alu_op_o`=0, `alu_src_imm_o`=0 and `dst_o`=0.
- R8: `reg_we_o` is 0 whenever the destination index is 0, even for an implemented operation.
- R9: The outputs show the decode of the word present at a rising clock edge where `en_i`=1. With `en_i`=0 they hold their values.
- R10: While reset is asserted, and until the second rising edge after it is released, `reg_we_o`, `jump_o` and `link_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Capture enable for the output register |
| instr_i | input | 32 | Instruction word |
| src_a_o | output | 5 | First source register index |
| src_b_o | output | 5 | Second source register index |
| dst_o | output | 5 | Destination register index |
| imm_o | output | 32 | Extended immediate |
| alu_op_o | output | 3 | ALU operation code |
| alu_src_imm_o | output | 1 | ALU operand B from immediate |
| reg_we_o | output | 1 | Register write enable |
| jump_o | output | 1 | Jump taken |
| link_o | output | 1 | Write PC+4 to the destination |

## Verification
The bench uses the default parameters: a 32-bit data path and register 31 as the link register. With a 32-bit word, the whole 6-bit opcode space and, under opcode 0, the whole 6-bit function space are small enough to sweep completely. The register and immediate fields vary arithmetically between words, and some are forced to zero so that destination-zero suppression and both extension polarities occur. Enable-low holding and the reset window are checked directly at the outputs.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;
  localparam int ALU_W   = 3;

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RA_LSB  = OPC_LSB - RIDX_W;
  localparam int RB_LSB  = RA_LSB - RIDX_W;
  localparam int RD_LSB  = RB_LSB - RIDX_W;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4,
    ALU_NOR = 3'd5
  } alu_sel_t;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RD   = 2'd1,
    DST_RT   = 2'd2,
    DST_LINK = 2'd3
  } dst_sel_t;

  typedef struct packed {
    alu_sel_t alu;
    logic     src_imm;
    logic     wr;
    dst_sel_t dst;
    logic     jump;
    logic     link;
    logic     sext;
  } ctrl_t;

  localparam logic [OPC_W-1:0] OP_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OP_J     = 6'b000010;
  localparam logic [OPC_W-1:0] OP_JL    = 6'b000011;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'b001001;
  localparam logic [OPC_W-1:0] OP_ANDI  = 6'b001100;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'b001101;
  localparam logic [OPC_W-1:0] OP_XORI  = 6'b001110;

  localparam logic [FN_W-1:0]  FN_ADD   = 6'b100001;
  localparam logic [FN_W-1:0]  FN_SUB   = 6'b100011;
  localparam logic [FN_W-1:0]  FN_AND   = 6'b100100;
  localparam logic [FN_W-1:0]  FN_OR    = 6'b100101;
  localparam logic [FN_W-1:0]  FN_XOR   = 6'b100110;
  localparam logic [FN_W-1:0]  FN_NOR   = 6'b100111;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
(
  input  logic [INSTR_W-1:0] word_i,
  output logic [OPC_W-1:0]   opc_o,
  output logic [FN_W-1:0]    fn_o,
  output logic [RIDX_W-1:0]  ra_o,
  output logic [RIDX_W-1:0]  rb_o,
  output logic [RIDX_W-1:0]  rd_o,
  output logic [IMM_W-1:0]   imm_o
);
  always_comb begin
    opc_o = word_i[OPC_LSB +: OPC_W];
    ra_o  = word_i[RA_LSB +: RIDX_W];
    rb_o  = word_i[RB_LSB +: RIDX_W];
    rd_o  = word_i[RD_LSB +: RIDX_W];
    fn_o  = word_i[FN_W-1:0];
    imm_o = word_i[IMM_W-1:0];
  end
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  output ctrl_t            ctrl_o
);
  ctrl_t idle;

  always_comb begin
    idle = '{alu: ALU_ADD, src_imm: 1'b0, wr: 1'b0, dst: DST_NONE,
             jump: 1'b0, link: 1'b0, sext: 1'b0};
    ctrl_o = idle;
    unique case (opc_i)
      OP_REG: begin
        ctrl_o.wr  = 1'b1;
        ctrl_o.dst = DST_RD;
        case (fn_i)
          FN_ADD:  ctrl_o.alu = ALU_ADD;
          FN_SUB:  ctrl_o.alu = ALU_SUB;
          FN_AND:  ctrl_o.alu = ALU_AND;
          FN_OR:   ctrl_o.alu = ALU_OR;
          FN_XOR:  ctrl_o.alu = ALU_XOR;
          FN_NOR:  ctrl_o.alu = ALU_NOR;
          default: ctrl_o = idle;
        endcase
      end
      OP_ADDI, OP_ANDI, OP_ORI, OP_XORI: begin
        ctrl_o.wr      = 1'b1;
        ctrl_o.dst     = DST_RT;
        ctrl_o.src_imm = 1'b1;
        case (opc_i)
          OP_ANDI: ctrl_o.alu = ALU_AND;
          OP_ORI:  ctrl_o.alu = ALU_OR;
          OP_XORI: ctrl_o.alu = ALU_XOR;
          default: ctrl_o.alu = ALU_ADD;
        endcase
      end
      OP_J: begin
        ctrl_o.jump = 1'b1;
      end
      OP_JL: begin
        ctrl_o.jump = 1'b1;
        ctrl_o.link = 1'b1;
        ctrl_o.wr   = 1'b1;
        ctrl_o.dst  = DST_LINK;
      end
      default: ctrl_o = idle;
    endcase
    ctrl_o.sext = (opc_i == OP_ADDI);
  end
endmodule

// File: rtl/idec_imm.sv
module idec_imm
  import idec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  raw_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] ext_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  generate
    if (PAD_W > 0) begin : g_pad
      logic fill;
      always_comb begin
        fill  = sext_i & raw_i[IMM_W-1];
        ext_o = {{PAD_W{fill}}, raw_i};
      end
    end else begin : g_trunc
      always_comb ext_o = raw_i[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/instr_decode_unit.sv
module instr_decode_unit
  import idec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LINK_REG = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [INSTR_W-1:0]  instr_i,
  output logic [RIDX_W-1:0]   src_a_o,
  output logic [RIDX_W-1:0]   src_b_o,
  output logic [RIDX_W-1:0]   dst_o,
  output logic [DATA_W-1:0]   imm_o,
  output logic [ALU_W-1:0]    alu_op_o,
  output logic                alu_src_imm_o,
  output logic                reg_we_o,
  output logic                jump_o,
  output logic                link_o
);
  localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

  typedef struct packed {
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [RIDX_W-1:0] dst;
    logic [DATA_W-1:0] imm;
    logic [ALU_W-1:0]  alu;
    logic              src_imm;
    logic              we;
    logic              jump;
    logic              link;
  } dec_out_t;

  logic [OPC_W-1:0]  opc;
  logic [FN_W-1:0]   fn;
  logic [RIDX_W-1:0] ra, rb, rd;
  logic [IMM_W-1:0]  imm_raw;
  logic [DATA_W-1:0] imm_ext;
  ctrl_t             ctrl;
  logic [RIDX_W-1:0] dst_idx;
  dec_out_t          dec, out_d, out_q;
  logic [1:0]        rst_pipe;
  logic              rst_int_n;

  idec_fields u_fields (
    .word_i (instr_i),
    .opc_o  (opc),
    .fn_o   (fn),
    .ra_o   (ra),
    .rb_o   (rb),
    .rd_o   (rd),
    .imm_o  (imm_raw)
  );

  idec_ctrl u_ctrl (
    .opc_i  (opc),
    .fn_i   (fn),
    .ctrl_o (ctrl)
  );

  idec_imm #(.DATA_W(DATA_W)) u_imm (
    .raw_i  (imm_raw),
    .sext_i (ctrl.sext),
    .ext_o  (imm_ext)
  );

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    unique case (ctrl.dst)
      DST_RD:   dst_idx = rd;
      DST_RT:   dst_idx = rb;
      DST_LINK: dst_idx = LINK_IDX;
      default:  dst_idx = '0;
    endcase
    dec.ra      = ra;
    dec.rb      = rb;
    dec.dst     = dst_idx;
    dec.imm     = imm_ext;
    dec.alu     = ctrl.alu;
    dec.src_imm = ctrl.src_imm;
    dec.we      = ctrl.wr && (dst_idx != '0);
    dec.jump    = ctrl.jump;
    dec.link    = ctrl.link;
  end

  always_comb begin
    out_d = out_q;
    if (en_i) out_d = dec;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_q <= '0;
    else            out_q <= out_d;
  end

  assign src_a_o       = out_q.ra;
  assign src_b_o       = out_q.rb;
  assign dst_o         = out_q.dst;
  assign imm_o         = out_q.imm;
  assign alu_op_o      = out_q.alu;
  assign alu_src_imm_o = out_q.src_imm;
  assign reg_we_o      = out_q.we;
  assign jump_o        = out_q.jump;
  assign link_o        = out_q.link;
endmodule

// File: rtl/instr_decode_unit_chk.sv
module instr_decode_unit_chk #(
  parameter int LINK_REG = 31
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic [4:0] dst_o,
  input logic [2:0] alu_op_o,
  input logic       alu_src_imm_o,
  input logic       reg_we_o,
  input logic       jump_o,
  input logic       link_o
);
  // R8
  zero_dst_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (dst_o != 5'd0));

  // R6
  link_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_o |-> (jump_o && reg_we_o && dst_o == 5'(LINK_REG)));

  // R5
  plain_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_o && !link_o) |-> (!reg_we_o && dst_o == 5'd0));

  // R3
  imm_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_src_imm_o |-> (!jump_o && alu_op_o != 3'd1 && alu_op_o != 3'd5));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> ($stable(dst_o) && $stable(reg_we_o) && $stable(jump_o)));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!reg_we_o && !jump_o && !link_o));
endmodule

bind instr_decode_unit instr_decode_unit_chk #(.LINK_REG(LINK_REG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_i          (en_i),
  .dst_o         (dst_o),
  .alu_op_o      (alu_op_o),
  .alu_src_imm_o (alu_src_imm_o),
  .reg_we_o      (reg_we_o),
  .jump_o        (jump_o),
  .link_o        (link_o)
);

// File: tb/instr_decode_unit_tb.sv
module instr_decode_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [4:0]  src_a_o, src_b_o, dst_o;
  logic [31:0] imm_o;
  logic [2:0]  alu_op_o;
  logic        alu_src_imm_o, reg_we_o, jump_o, link_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  instr_decode_unit dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .instr_i(instr_i),
    .src_a_o(src_a_o), .src_b_o(src_b_o), .dst_o(dst_o), .imm_o(imm_o),
    .alu_op_o(alu_op_o), .alu_src_imm_o(alu_src_imm_o),
    .reg_we_o(reg_we_o), .jump_o(jump_o), .link_o(link_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // expected outputs from the requirement text
  task automatic expect_word(input logic [31:0] w);
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd, e_dst;
    logic [2:0] e_alu;
    logic e_imm_sel, e_we, e_j, e_l, ok;
    logic [31:0] e_imm;
    op = w[31:26]; fn = w[5:0]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
    e_alu = 3'd0; e_imm_sel = 1'b0; e_dst = 5'd0; e_j = 1'b0; e_l = 1'b0; ok = 1'b0;
    if (op == 6'b000000) begin
      ok = 1'b1; e_dst = rd;
      case (fn)
        6'b100001: e_alu = 3'd0;
        6'b100011: e_alu = 3'd1;
        6'b100100: e_alu = 3'd2;
        6'b100101: e_alu = 3'd3;
        6'b100110: e_alu = 3'd4;
        6'b100111: e_alu = 3'd5;
        default: begin ok = 1'b0; e_dst = 5'd0; end
      endcase
    end else if (op == 6'b001001 || op == 6'b001100 || op == 6'b001101 || op == 6'b001110) begin
      ok = 1'b1; e_dst = rt; e_imm_sel = 1'b1;
      e_alu = (op == 6'b001100) ? 3'd2 : (op == 6'b001101) ? 3'd3 :
              (op == 6'b001110) ? 3'd4 : 3'd0;
    end else if (op == 6'b000010) begin
      e_j = 1'b1;
    end else if (op == 6'b000011) begin
      e_j = 1'b1; e_l = 1'b1; ok = 1'b1; e_dst = 5'd31;
    end
    e_we = ok && (e_dst != 5'd0);
    e_imm = (op == 6'b001001) ? {{16{w[15]}}, w[15:0]} : {16'h0, w[15:0]};
    check("R1", "src_a", 32'(src_a_o), 32'(rs));
    check("R1", "src_b", 32'(src_b_o), 32'(rt));
    check("R2_R3_R7", "alu_op", 32'(alu_op_o), 32'(e_alu));
    check("R3_R7", "alu_src_imm", 32'(alu_src_imm_o), 32'(e_imm_sel));
    check("R2_R3_R6", "dst", 32'(dst_o), 32'(e_dst));
    check("R4", "imm", imm_o, e_imm);
    check("R7_R8", "reg_we", 32'(reg_we_o), 32'(e_we));
    check("R5_R6", "jump", 32'(jump_o), 32'(e_j));
    check("R6", "link", 32'(link_o), 32'(e_l));
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr_i = w; en_i = 1'b1;
    @(negedge clk);
    en_i = 1'b0;
    expect_word(w);
  endtask

  function automatic logic [31:0] make_word(input int op, input int fn, input int k);
    logic [4:0] rs, rt, rd, sh;
    logic [15:0] im;
    rs = 5'((k * 7 + 3) % 32);
    rt = (k % 5 == 0) ? 5'd0 : 5'((k * 13 + 1) % 32);
    rd = (k % 7 == 0) ? 5'd0 : 5'((k * 11 + 5) % 32);
    sh = 5'((k * 3) % 32);
    im = 16'((k * 2741) ^ (k << 9));
    if (op != 0) return {6'(op), rs, rt, im};
    return {6'(op), rs, rt, rd, sh, 6'(fn)};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int k;
    logic [4:0] h_dst;
    logic h_we;
    k = 0;
    instr_i = {6'b000011, 26'h0};
    en_i = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "reg_we_rst", 32'(reg_we_o), 32'd0);
    check("R10", "jump_rst", 32'(jump_o), 32'd0);
    check("R10", "link_rst", 32'(link_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: first edge after release still in reset window
    check("R10", "we_sync", 32'(reg_we_o), 32'd0);
    check("R10", "jump_sync", 32'(jump_o), 32'd0);
    en_i = 1'b0;
    @(negedge clk);

    // full sweep of opcodes, and of function codes under opcode 0
    for (int op = 0; op < 64; op++) begin
      if (op == 0) begin
        for (int fn = 0; fn < 64; fn++) begin
          apply(make_word(0, fn, k)); k++;
          apply(make_word(0, fn, k)); k++;
        end
      end else begin
        for (int r = 0; r < 8; r++) begin
          apply(make_word(op, 0, k)); k++;
        end
      end
    end

    // R4: immediate sign boundaries
    apply({6'b001001, 5'd1, 5'd2, 16'h8000});
    apply({6'b001001, 5'd1, 5'd2, 16'h7fff});
    apply({6'b001100, 5'd1, 5'd2, 16'hffff});
    // R8: destination zero for each class
    apply({6'b000000, 5'd4, 5'd5, 5'd0, 5'd0, 6'b100001});
    apply({6'b001101, 5'd4, 5'd0, 16'h1234});

    // R9: enable low holds the previous decode
    apply({6'b000011, 26'h155});
    h_dst = dst_o; h_we = reg_we_o;
    @(negedge clk);
    instr_i = {6'b000000, 5'd1, 5'd2, 5'd3, 5'd0, 6'b100011};
    en_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9", "hold_dst", 32'(dst_o), 32'(h_dst));
    check("R9", "hold_we", 32'(reg_we_o), 32'(h_we));
    check("R9", "hold_link", 32'(link_o), 32'd1);
    en_i = 1'b1;
    @(negedge clk);
    en_i = 1'b0;
    check("R9", "capture_dst", 32'(dst_o), 32'd3);
    check("R9", "capture_alu", 32'(alu_op_o), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule